// File: doc/BRIEF.md
# Multibank Conflict-Resolving Vector Memory

This block is a banked data store that takes one vector of P independent accesses per clock, where P is a power of two. Each lane of a vector carries an index and a lane-valid bit, and the whole vector is either a read or a write. The low bits of an index select a bank and the upper bits give the word inside that bank. An optional address-dependent rotation of the bank number can be switched on per vector. It spreads the accesses of regular patterns, such as a matrix transpose, over the banks.

Every bank owns a queue of P pending accesses and executes at most one access per cycle. Lanes of one vector that land in the same bank queue up behind each other, so conflicts cost time and never cause errors. A vector enters the queues whole or not at all. When any bank queue lacks room, the block raises a stall and the producer holds the vector. Read data from every bank collects in a per-bank reorder queue of depth P. A read vector is released only when all of its lanes are present. Its data comes out in lane order, and read vectors leave in the order they were issued. A consumer that deasserts its ready freezes every bank.

Top module: `cr_mem`

## Requirements
- R1: With `perm_en` low, lane index `i` addresses bank `i mod P` (its low log2 P bits) at local word `i div P` (the remaining upper bits).
- R2: With `perm_en` high, the local word is unchanged, and the bank becomes `(b + a/P + a/P^2 + ... ) mod P`. Here b and a are the R1 bank and word, the divisions are integer divisions, and the sum holds every term whose shift is smaller than the word width.
- R3: A presented vector is taken only if every bank queue, at its current occupancy, can hold all of that vector's lanes for the bank (each queue holds P entries). A read is also refused while the record of outstanding read vectors is full. Otherwise `in_stall` is high and nothing of that vector is stored.
- R4: Each bank executes at most one queued access per cycle, and only while `out_ready` is high. While `out_ready` is low, no access executes and no read result appears.
- R5: `out_valid` rises only when every valid lane of the oldest outstanding read vector has its data. `out_rdata` lane j (bits j*DW up) holds lane j's word, invalid lanes read as zero, and `out_lane_vld` repeats the lane mask. Read vectors leave strictly in issue order.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_rdata` hold their values.
- R7: Accesses are applied in acceptance order. A read sees every earlier accepted write to the same location. When several lanes of one write vector hit one location, the highest-numbered lane wins.
- R8: During and right after reset, `out_valid` and `in_stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A vector is presented |
| in_write | input | 1 | 1 = write vector, 0 = read vector |
| perm_en | input | 1 | Enables the bank rotation for this vector |
| in_lane_vld | input | P | Per-lane valid mask |
| in_idx | input | P*(AW+log2 P) | Per-lane index, lane j in slice j |
| in_wdata | input | P*DW | Per-lane write data |
| in_stall | output | 1 | Presented vector is not taken this cycle |
| out_valid | output | 1 | A complete read vector is available |
| out_ready | input | 1 | Consumer takes the vector; low freezes the banks |
| out_lane_vld | output | P | Lane mask of the vector on the output |
| out_rdata | output | P*DW | Read data in lane order |

## Verification
The bound checker watches, on every cycle, that no access or reorder queue exceeds P entries, and that a refused vector leaves the queues unchanged while the banks are frozen. It also checks that queues never shrink while `out_ready` is low, and that a waiting output vector holds steady. The placement rules (R1, R2), the write-ordering and duplicate-lane rule (R7), and the return of read data in lane and issue order (R5) only show in the bench. The bench compares each released vector against a physical-location model of the banks, and it adds directed cases: one bank filled to capacity, a vector withdrawn after a refusal, and a write under the rotation read back without it.

// File: rtl/cr_pkg.sv
package cr_pkg;
  // Kind of a presented vector, as carried on in_write.
  typedef enum logic {
    CR_OP_READ  = 1'b0,
    CR_OP_WRITE = 1'b1
  } cr_op_e;
endpackage

// File: rtl/cr_lane_rank.sv
// Per-bank lane counts and per-lane rank among lanes sharing a bank.
module cr_lane_rank #(
  parameter int P  = 8,
  parameter int LP = 3,
  parameter int CW = 4
) (
  input  logic [P-1:0]         lv,
  input  logic [P-1:0][LP-1:0] lb,
  output logic [P-1:0][LP-1:0] rank,
  output logic [P-1:0][CW-1:0] need
);
  always_comb begin
    rank = '0;
    need = '0;
    for (int j = 0; j < P; j++) begin
      for (int i = 0; i < j; i++) begin
        if (lv[i] && (lb[i] == lb[j])) rank[j] = rank[j] + LP'(1);
      end
      if (lv[j]) need[lb[j]] = need[lb[j]] + CW'(1);
    end
  end
endmodule

// File: rtl/cr_track.sv
// FIFO of outstanding read-vector records (lane mask and lane banks).
module cr_track #(
  parameter int W = 32,
  parameter int D = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] rec,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(D);
  localparam int NW = $clog2(D + 1);

  logic [W-1:0]  mem [D];
  logic [PW-1:0] wr_q, rd_q, wr_n, rd_n;
  logic [NW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == NW'(D));
  assign head    = mem[rd_q];

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q + NW'(do_push) - NW'(do_pop);
    if (do_push) wr_n = (wr_q == PW'(D - 1)) ? '0 : wr_q + PW'(1);
    if (do_pop)  rd_n = (rd_q == PW'(D - 1)) ? '0 : rd_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= rec;
  end
endmodule

// File: rtl/cr_bank.sv
// One bank: access queue of depth P, single-port word array, reorder queue of depth P.
module cr_bank #(
  parameter int P  = 8,
  parameter int DW = 8,
  parameter int AW = 7,
  parameter int LP = 3,
  parameter int CW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push_en,
  input  logic [CW-1:0]        push_cnt,
  input  logic                 push_we,
  input  logic [P-1:0][AW-1:0] push_addr,
  input  logic [P-1:0][DW-1:0] push_data,
  input  logic                 go,
  input  logic [CW-1:0]        pop_cnt,
  output logic [CW-1:0]        aq_cnt,
  output logic [CW-1:0]        rq_cnt,
  output logic [P-1:0][DW-1:0] rq_win
);
  logic          aq_we   [P];
  logic [AW-1:0] aq_addr [P];
  logic [DW-1:0] aq_data [P];
  logic [DW-1:0] words   [2**AW];
  logic [DW-1:0] rq_mem  [P];

  logic [LP-1:0] aq_wr_q, aq_rd_q, aq_wr_n, aq_rd_n;
  logic [LP-1:0] rq_wr_q, rq_rd_q, rq_wr_n, rq_rd_n;
  logic [CW-1:0] aq_cnt_n, rq_cnt_n;
  logic          rd_pend_q, exec, room, head_we;
  logic [DW-1:0] rdata_q;

  assign head_we = aq_we[aq_rd_q];
  assign room    = (rq_cnt + CW'(rd_pend_q)) < CW'(P);
  assign exec    = (aq_cnt != '0) && go && (head_we || room);

  always_comb begin
    aq_cnt_n = aq_cnt + (push_en ? push_cnt : '0) - CW'(exec);
    aq_wr_n  = aq_wr_q + (push_en ? LP'(push_cnt) : '0);
    aq_rd_n  = aq_rd_q + LP'(exec);
    rq_cnt_n = rq_cnt + CW'(rd_pend_q) - pop_cnt;
    rq_wr_n  = rq_wr_q + LP'(rd_pend_q);
    rq_rd_n  = rq_rd_q + LP'(pop_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aq_cnt    <= '0;
      aq_wr_q   <= '0;
      aq_rd_q   <= '0;
      rq_cnt    <= '0;
      rq_wr_q   <= '0;
      rq_rd_q   <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      aq_cnt    <= aq_cnt_n;
      aq_wr_q   <= aq_wr_n;
      aq_rd_q   <= aq_rd_n;
      rq_cnt    <= rq_cnt_n;
      rq_wr_q   <= rq_wr_n;
      rq_rd_q   <= rq_rd_n;
      rd_pend_q <= exec && !head_we;
    end
  end

  // Storage without reset: queue slots, bank array, read register.
  always_ff @(posedge clk) begin
    for (int i = 0; i < P; i++) begin
      if (push_en && (CW'(i) < push_cnt)) begin
        aq_we[aq_wr_q + LP'(i)]   <= push_we;
        aq_addr[aq_wr_q + LP'(i)] <= push_addr[i];
        aq_data[aq_wr_q + LP'(i)] <= push_data[i];
      end
    end
    if (exec && head_we)  words[aq_addr[aq_rd_q]] <= aq_data[aq_rd_q];
    if (exec && !head_we) rdata_q <= words[aq_addr[aq_rd_q]];
    if (rd_pend_q)        rq_mem[rq_wr_q] <= rdata_q;
  end

  always_comb begin
    for (int j = 0; j < P; j++) rq_win[j] = rq_mem[rq_rd_q + LP'(j)];
  end
endmodule

// File: rtl/cr_mem.sv
module cr_mem #(
  parameter int P    = 8,
  parameter int DW   = 8,
  parameter int AW   = 7,
  parameter int VQ_D = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  input  logic                                in_write,
  input  logic                                perm_en,
  input  logic [P-1:0]                        in_lane_vld,
  input  logic [P-1:0][AW+$clog2(P)-1:0]      in_idx,
  input  logic [P-1:0][DW-1:0]                in_wdata,
  output logic                                in_stall,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [P-1:0]                        out_lane_vld,
  output logic [P-1:0][DW-1:0]                out_rdata
);
  import cr_pkg::*;

  localparam int LP    = $clog2(P);
  localparam int IDX_W = AW + LP;
  localparam int CW    = $clog2(P + 1);
  localparam int NTERM = (AW - 1) / LP;
  localparam int RW    = P * (1 + LP);

  // Bank of one index, with the optional rotation by folded word bits.
  function automatic logic [LP-1:0] phys_bank(input logic [IDX_W-1:0] idx, input logic en);
    logic [LP-1:0] s;
    logic [AW-1:0] a;
    a = idx[IDX_W-1:LP];
    s = idx[LP-1:0];
    if (en) begin
      for (int k = 1; k <= NTERM; k++) s = s + LP'(a >> (LP * k));
    end
    return s;
  endfunction

  logic [P-1:0][LP-1:0]        lb, rank, hb, hrank;
  logic [P-1:0][AW-1:0]        la;
  logic [P-1:0][CW-1:0]        need, hneed, pop_cnt, aq_cnt, rq_cnt;
  logic [P-1:0][P-1:0][AW-1:0] bp_addr;
  logic [P-1:0][P-1:0][DW-1:0] bp_data;
  logic [P-1:0][P-1:0][DW-1:0] rq_win;
  logic [P-1:0]                hv;
  logic [RW-1:0]               trk_head;
  logic                        trk_empty, trk_full, fits, acc, rel, is_rd;

  assign is_rd = (cr_op_e'(in_write) == CR_OP_READ);

  always_comb begin
    for (int j = 0; j < P; j++) begin
      lb[j] = phys_bank(in_idx[j], perm_en);
      la[j] = in_idx[j][IDX_W-1:LP];
    end
  end

  cr_lane_rank #(.P(P), .LP(LP), .CW(CW)) u_in_rank (
    .lv(in_lane_vld), .lb(lb), .rank(rank), .need(need)
  );

  always_comb begin
    fits = 1'b1;
    for (int b = 0; b < P; b++) begin
      if (({1'b0, aq_cnt[b]} + {1'b0, need[b]}) > (CW + 1)'(P)) fits = 1'b0;
    end
  end

  assign in_stall = in_valid && (!fits || (is_rd && trk_full));
  assign acc      = in_valid && !in_stall;

  // Steer every valid lane to its bank slot (rank among same-bank lanes).
  always_comb begin
    bp_addr = '0;
    bp_data = '0;
    for (int j = 0; j < P; j++) begin
      if (in_lane_vld[j]) begin
        bp_addr[lb[j]][rank[j]] = la[j];
        bp_data[lb[j]][rank[j]] = in_wdata[j];
      end
    end
  end

  for (genvar b = 0; b < P; b++) begin : g_bank
    cr_bank #(.P(P), .DW(DW), .AW(AW), .LP(LP), .CW(CW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_en   (acc),
      .push_cnt  (need[b]),
      .push_we   (in_write),
      .push_addr (bp_addr[b]),
      .push_data (bp_data[b]),
      .go        (out_ready),
      .pop_cnt   (pop_cnt[b]),
      .aq_cnt    (aq_cnt[b]),
      .rq_cnt    (rq_cnt[b]),
      .rq_win    (rq_win[b])
    );
  end

  cr_track #(.W(RW), .D(VQ_D)) u_track (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (acc && is_rd),
    .rec   ({lb, in_lane_vld}),
    .pop   (rel),
    .head  (trk_head),
    .empty (trk_empty),
    .full  (trk_full)
  );

  assign hv = trk_head[P-1:0];
  assign hb = trk_head[RW-1:P];

  cr_lane_rank #(.P(P), .LP(LP), .CW(CW)) u_head_rank (
    .lv(hv), .lb(hb), .rank(hrank), .need(hneed)
  );

  always_comb begin
    out_valid = !trk_empty;
    for (int b = 0; b < P; b++) begin
      if (rq_cnt[b] < hneed[b]) out_valid = 1'b0;
    end
    for (int j = 0; j < P; j++) begin
      out_rdata[j] = hv[j] ? rq_win[hb[j]][hrank[j]] : '0;
    end
    out_lane_vld = out_valid ? hv : '0;
  end

  assign rel = out_valid && out_ready;

  always_comb begin
    for (int b = 0; b < P; b++) pop_cnt[b] = rel ? hneed[b] : '0;
  end
endmodule

// File: rtl/cr_mem_chk.sv
module cr_mem_chk #(
  parameter int P  = 8,
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_stall,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [P-1:0][DW-1:0] out_rdata,
  input logic [P-1:0][CW-1:0] aq_cnt,
  input logic [P-1:0][CW-1:0] rq_cnt
);
  for (genvar b = 0; b < P; b++) begin : g_bank_chk
    p_cap_aq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      aq_cnt[b] <= CW'(P));
    p_cap_rq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rq_cnt[b] <= CW'(P));
    p_drain_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |=> aq_cnt[b] >= $past(aq_cnt[b]));
  end

  p_atomic_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stall && !out_ready) |=> $stable(aq_cnt));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rdata)));
endmodule

bind cr_mem cr_mem_chk #(.P(P), .DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_stall  (in_stall),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_rdata (out_rdata),
  .aq_cnt    (aq_cnt),
  .rq_cnt    (rq_cnt)
);

// File: tb/cr_mem_tb_top.sv
module cr_mem_tb_top;
  localparam int P     = 8;
  localparam int DW    = 8;
  localparam int AW    = 7;
  localparam int LP    = 3;
  localparam int IDX_W = AW + LP;
  localparam int NW    = P * (2 ** AW);

  logic                         clk = 1'b0;
  logic                         rst_n;
  logic                         in_valid, in_write, perm_en, out_ready;
  logic [P-1:0]                 in_lane_vld, out_lane_vld;
  logic [P-1:0][IDX_W-1:0]      in_idx;
  logic [P-1:0][DW-1:0]         in_wdata, out_rdata;
  logic                         in_stall, out_valid;

  always #2.5 clk = ~clk;

  cr_mem #(.P(P), .DW(DW), .AW(AW), .VQ_D(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_write(in_write),
    .perm_en(perm_en), .in_lane_vld(in_lane_vld), .in_idx(in_idx),
    .in_wdata(in_wdata), .in_stall(in_stall), .out_valid(out_valid),
    .out_ready(out_ready), .out_lane_vld(out_lane_vld), .out_rdata(out_rdata)
  );

  int unsigned        n_run = 0, n_fail = 0;
  int                 rdy_mode = 2;   // 0 random, 1 held low, 2 held high
  bit                 done = 1'b0;
  logic [DW-1:0]      pm [NW];        // model indexed by physical bank*2^AW + word
  logic [P*DW-1:0]    exp_q [$];
  logic [P-1:0]       msk_q [$];
  string              tag_q [$];
  bit                 hold_chk = 1'b0;
  logic [P*DW-1:0]    hold_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Physical location from the placement rules (R1, R2).
  function automatic int phys(input logic [IDX_W-1:0] idx, input logic pe);
    int a, b;
    a = int'(idx) / P;
    b = int'(idx) % P;
    if (pe) begin
      for (int k = 1; LP * k < AW; k++) b = b + (a >> (LP * k));
      b = b % P;
    end
    return b * (2 ** AW) + a;
  endfunction

  task automatic finish_tb;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Present one vector until it is accepted; returns cycles spent stalled.
  task automatic send(input logic wr, input logic pe, input logic [P-1:0] lv,
                      input logic [P-1:0][IDX_W-1:0] ix,
                      input logic [P-1:0][DW-1:0] wd, input string tag,
                      output int stalls);
    logic [P*DW-1:0] e;
    stalls   = 0;
    in_valid = 1'b1; in_write = wr; perm_en = pe;
    in_lane_vld = lv; in_idx = ix; in_wdata = wd;
    forever begin
      #1;
      if (!in_stall) break;
      stalls++;
      @(negedge clk);
    end
    if (wr) begin
      for (int j = 0; j < P; j++) if (lv[j]) pm[phys(ix[j], pe)] = wd[j];
    end else begin
      e = '0;
      for (int j = 0; j < P; j++) if (lv[j]) e[j*DW +: DW] = pm[phys(ix[j], pe)];
      exp_q.push_back(e); msk_q.push_back(lv); tag_q.push_back(tag);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Output monitor: ready pattern, hold check (R6), ordered data check (R5).
  always @(negedge clk) begin
    if (rdy_mode == 0) out_ready = (($urandom % 4) != 0);
    else               out_ready = (rdy_mode == 2);
    #1;
    if (rst_n === 1'b1) begin
      if (hold_chk)
        chk(out_valid && (out_rdata == hold_data), "R6", "held output",
            {out_valid, out_rdata[P*DW-2:0]}, {1'b1, hold_data[P*DW-2:0]});
      hold_chk  = out_valid && !out_ready;
      hold_data = out_rdata;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected vector", out_rdata, '0);
        end else begin
          logic [P*DW-1:0] e;
          logic [P-1:0]    m;
          string           t;
          e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
          chk(out_rdata == e, t, "read data", out_rdata, e);
          chk(out_lane_vld == m, "R5", "lane mask", 64'(out_lane_vld), 64'(m));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R5", "watchdog expired", 64'(exp_q.size()), 0);
    finish_tb();
  end

  initial begin
    logic [P-1:0][IDX_W-1:0] ix;
    logic [P-1:0][DW-1:0]    wd;
    int                      st;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_write = 1'b0; perm_en = 1'b0;
    in_lane_vld = '0; in_idx = '0; in_wdata = '0;
    repeat (4) @(negedge clk);
    #1;
    chk(!out_valid && !in_stall, "R8", "in reset", {out_valid, in_stall}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!out_valid && !in_stall, "R8", "after reset", {out_valid, in_stall}, 0);
    @(negedge clk);

    // Linear preload and linear readback (R1 placement, no conflicts).
    for (int v = 0; v < NW / P; v++) begin
      for (int j = 0; j < P; j++) begin
        ix[j] = IDX_W'(v * P + j);
        wd[j] = DW'(v * P + j) ^ 8'h5A;
      end
      send(1'b1, 1'b0, '1, ix, wd, "R1", st);
    end
    for (int v = 0; v < 16; v++) begin
      for (int j = 0; j < P; j++) ix[j] = IDX_W'(v * P + j);
      send(1'b0, 1'b0, '1, ix, wd, "R1", st);
    end

    // All lanes in bank 3: conflicts resolved, lane order kept (R5).
    for (int j = 0; j < P; j++) ix[j] = IDX_W'(j * P + 3);
    send(1'b0, 1'b0, '1, ix, wd, "R5", st);
    send(1'b0, 1'b0, 8'b1010_0101, ix, wd, "R5", st);

    // Duplicate-index write: highest lane wins (R7).
    for (int j = 0; j < P; j++) begin ix[j] = IDX_W'(5); wd[j] = DW'(8'h30 + j); end
    send(1'b1, 1'b0, '1, ix, wd, "R7", st);
    ix[3] = IDX_W'(5);
    send(1'b0, 1'b0, 8'b0000_1000, ix, wd, "R7", st);

    // Rotation: index 74 (word 9, bank 2) goes to bank 3 with perm_en (R2).
    ix[0] = IDX_W'(74); wd[0] = 8'hA5;
    send(1'b1, 1'b1, 8'b0000_0001, ix, wd, "R2", st);
    ix[0] = IDX_W'(75); ix[1] = IDX_W'(74); ix[2] = IDX_W'(1021);
    send(1'b0, 1'b0, 8'b0000_0111, ix, wd, "R2", st);
    send(1'b0, 1'b1, 8'b0000_0110, ix, wd, "R2", st);
    repeat (40) @(negedge clk);

    // Frozen banks: read must not return while out_ready is low (R4).
    rdy_mode = 1;
    repeat (2) @(negedge clk);
    ix[0] = IDX_W'(2); ix[1] = IDX_W'(10);
    send(1'b0, 1'b0, 8'b0000_0011, ix, wd, "R4", st);
    repeat (5) @(negedge clk);
    #1;
    chk(!out_valid, "R4", "no result while frozen", 64'(out_valid), 0);
    @(negedge clk);

    // Fill bank 0 with P writes, then a vector needing bank 0 is refused (R3).
    for (int j = 0; j < P; j++) begin ix[j] = IDX_W'(j * P); wd[j] = DW'(8'h10 + j); end
    send(1'b1, 1'b0, '1, ix, wd, "R3", st);
    chk(st == 0, "R3", "empty bank takes P lanes", 64'(st), 0);
    in_valid = 1'b1; in_write = 1'b1; perm_en = 1'b0; in_lane_vld = 8'b0000_0011;
    in_idx[0] = IDX_W'(1); in_wdata[0] = 8'hEE;
    in_idx[1] = IDX_W'(64); in_wdata[1] = 8'hEF;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(in_stall, "R3", "stall on full bank", 64'(in_stall), 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    // Bank 1 alone still has room: index 9 maps to bank 1 (R1).
    ix[0] = IDX_W'(9);
    send(1'b0, 1'b0, 8'b0000_0001, ix, wd, "R1", st);
    chk(st == 0, "R1", "bank-1 read not stalled", 64'(st), 0);
    rdy_mode = 2;
    // The refused vector left indices 1 and 64 untouched (R3).
    ix[0] = IDX_W'(1); ix[1] = IDX_W'(64); ix[2] = IDX_W'(0); ix[3] = IDX_W'(56);
    send(1'b0, 1'b0, 8'b0000_1111, ix, wd, "R3", st);

    // Random mix of reads and writes with clustered indices (R7, R5).
    rdy_mode = 0;
    for (int v = 0; v < 600; v++) begin
      logic [P-1:0] lv;
      int           cb;
      cb = int'($urandom % P);
      for (int j = 0; j < P; j++) begin
        if (($urandom % 2) == 0) ix[j] = IDX_W'(($urandom % (2 ** AW)) * P + cb);
        else                     ix[j] = IDX_W'($urandom % NW);
        wd[j] = DW'($urandom);
      end
      lv = P'($urandom);
      send(($urandom % 2) == 0, ($urandom % 2) == 0, lv, ix, wd, "R7", st);
    end

    rdy_mode = 2;
    for (int c = 0; c < 3000 && exp_q.size() != 0; c++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "all reads returned", 64'(exp_q.size()), 0);
    finish_tb();
  end
endmodule